// File: doc/BRIEF.md
# Sequential Multiply and Divide Unit

This unit is the arithmetic helper of an 8-bit CPU datapath for the operations that take many cycles. It has three operations. The first multiplies the two byte halves of a 16-bit operand, giving a 16-bit product. The second divides one unsigned 16-bit value by another and returns both the quotient and the remainder. The third is a fractional divide. It divides a numerator by a larger denominator and returns a 16-bit binary fraction together with a remainder. That remainder can be fed back in as the next numerator to extend the fraction by another 16 bits.

The CPU presents a dividend/operand word `d_in` and a divisor word `x_in`, selects an operation and raises `start` for one cycle. The unit captures the operands, runs one result bit per cycle, and raises `done` for one cycle. At that point the new values for the two CPU registers and three flags are valid on the outputs, where they hold until the next result.

- The multiply is a shift-and-add over 8 steps.
- Both divides use one restoring shift-and-subtract datapath over 16 steps.
- Divide by zero and fractional overflow are flagged, and the quotient is forced to all ones.

Top module: `muldiv_unit`

## Requirements
- R1: With op code 0 (multiply), `res_d` becomes `d_in[15:8] * d_in[7:0]`, `res_x` becomes the captured `x_in`, `flag_c` equals bit 7 of the product and `flag_v` is 0.
- R2: With op code 1 (integer divide) and a nonzero divisor, `res_x` is floor(d_in / x_in), `res_d` is d_in mod x_in, and `flag_c` and `flag_v` are 0.
- R3: With op code 2 (fractional divide) and d_in < x_in, `res_x` is floor(d_in * 65536 / x_in) and `res_d` is (d_in * 65536) mod x_in. Feeding `res_d` back as the numerator with the same divisor yields the next 16 fraction bits.
- R4: A divide of either kind with x_in = 0 sets `flag_c`, drives `res_x` to 0xFFFF and returns the captured `d_in` on `res_d`. A fractional divide by zero also sets `flag_v`.
- R5: A fractional divide with x_in nonzero and d_in >= x_in sets `flag_v`, clears `flag_c`, drives `res_x` to 0xFFFF and returns the captured `d_in` on `res_d`.
- R6: `flag_z` is 1 exactly when the main result is zero. For the divides the main result is `res_x`; for the multiply it is `res_d`.
- R7: A start is accepted on a rising edge where `busy` is 0. From the next cycle `busy` is 1. `done` is a single-cycle pulse that appears 8 cycles after acceptance for the multiply and 16 cycles after acceptance for the divides; in that same cycle `busy` returns to 0.
- R8: A start that arrives while `busy` is 1 is ignored. The running operation completes with its original operands and produces exactly one `done`.
- R9: A start with op code 3 is ignored: `busy` stays 0 and no `done` follows.
- R10: While reset is held, and after it, `busy`, `done`, all results and all flags are 0. Results and flags keep their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 0 multiply, 1 integer divide, 2 fractional divide, 3 no operation |
| d_in | input | 16 | Dividend or numerator; multiply operands in the high and low bytes |
| x_in | input | 16 | Divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| res_x | output | 16 | Quotient (divides) or unchanged x_in (multiply) |
| res_d | output | 16 | Remainder (divides) or product (multiply) |
| flag_c | output | 1 | Divide by zero, or product bit 7 for rounding |
| flag_v | output | 1 | Fractional divide overflow |
| flag_z | output | 1 | Main result is zero |

## Verification
Every result is due at a fixed distance from the accepting edge. For the multiply that distance is 8 cycles, and for both divides it is 16 cycles, independent of the operands and of the special cases.

The driver records the rising-edge count at which it raises `start`. It files the expected values with a due count equal to that count, plus one for the accepting edge, plus the step count. The monitor samples `done` at falling edges and compares both the values and the edge count at which each result appears.

A `done` that arrives with nothing pending is counted as a failure. This covers both a restart caused by a `start` issued while busy and a spurious result from op code 3.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_IDIV = 2'd1,
    OP_FDIV = 2'd2,
    OP_NONE = 2'd3
  } op_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] count,
  output logic          busy,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= count;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/muldiv_mulstep.sv
module muldiv_mulstep #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic [W-1:0] acc,
  input  logic [H-1:0] mcand,
  output logic [W-1:0] acc_nxt
);
  logic [H:0] sum;

  always_comb begin
    sum     = {1'b0, acc[W-1:H]} + (acc[0] ? {1'b0, mcand} : '0);
    acc_nxt = {sum, acc[H-1:1]};
  end
endmodule

// File: rtl/muldiv_divstep.sv
module muldiv_divstep #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] den,
  output logic [W-1:0] rem_nxt,
  output logic [W-1:0] quo_nxt
);
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         borrow;

  always_comb begin
    shifted = {rem, quo[W-1]};
    diff    = {1'b0, shifted} - {2'b00, den};
    borrow  = diff[W+1];
    rem_nxt = borrow ? shifted[W-1:0] : diff[W-1:0];
    quo_nxt = {quo[W-2:0], ~borrow};
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] x_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_x,
  output logic [W-1:0] res_d,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_z
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W + 1);

  op_e           op_q;
  logic [W-1:0]  rem_q, quo_q, den_q, hold_q;
  logic          dz_q, ov_q;
  logic          accept, last;
  logic [CW-1:0] steps;
  logic [W-1:0]  mul_nxt, rem_nxt, quo_nxt;

  assign accept = start && !busy && (op != OP_NONE);
  assign steps  = (op == OP_MUL) ? CW'(H) : CW'(W);

  muldiv_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .load(accept), .count(steps),
    .busy(busy), .last(last)
  );

  muldiv_mulstep #(.W(W)) u_mul (
    .acc(quo_q), .mcand(den_q[H-1:0]), .acc_nxt(mul_nxt)
  );

  muldiv_divstep #(.W(W)) u_div (
    .rem(rem_q), .quo(quo_q), .den(den_q),
    .rem_nxt(rem_nxt), .quo_nxt(quo_nxt)
  );

  // operand capture and iteration
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_MUL;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      hold_q <= '0;
      dz_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else if (accept) begin
      op_q <= op_e'(op);
      dz_q <= (x_in == '0);
      ov_q <= (op == OP_FDIV) && (d_in >= x_in);
      case (op)
        OP_MUL: begin
          quo_q  <= {{H{1'b0}}, d_in[H-1:0]};
          den_q  <= {{H{1'b0}}, d_in[W-1:H]};
          rem_q  <= '0;
          hold_q <= x_in;
        end
        OP_FDIV: begin
          quo_q  <= '0;
          rem_q  <= d_in;
          den_q  <= x_in;
          hold_q <= d_in;
        end
        default: begin
          quo_q  <= d_in;
          rem_q  <= '0;
          den_q  <= x_in;
          hold_q <= d_in;
        end
      endcase
    end else if (busy) begin
      if (op_q == OP_MUL) begin
        quo_q <= mul_nxt;
      end else begin
        quo_q <= quo_nxt;
        rem_q <= rem_nxt;
      end
    end
  end

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      res_x  <= '0;
      res_d  <= '0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      done <= busy && last;
      if (busy && last) begin
        if (op_q == OP_MUL) begin
          res_d  <= mul_nxt;
          res_x  <= hold_q;
          flag_c <= mul_nxt[H-1];
          flag_v <= 1'b0;
          flag_z <= (mul_nxt == '0);
        end else if (dz_q || ov_q) begin
          res_x  <= '1;
          res_d  <= hold_q;
          flag_c <= dz_q;
          flag_v <= ov_q;
          flag_z <= 1'b0;
        end else begin
          res_x  <= quo_nxt;
          res_d  <= rem_nxt;
          flag_c <= 1'b0;
          flag_v <= 1'b0;
          flag_z <= (quo_nxt == '0);
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] d_in,
  input logic [W-1:0] x_in,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_x,
  input logic [W-1:0] res_d,
  input logic         flag_c,
  input logic         flag_v,
  input logic         flag_z
);
  localparam int H = W / 2;

  logic [1:0]   cap_op;
  logic [W-1:0] cap_d, cap_x;
  logic [7:0]   lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_op <= '0;
      cap_d  <= '0;
      cap_x  <= '0;
      lat    <= '0;
    end else if (start && !busy && op != 2'd3) begin
      cap_op <= op;
      cap_d  <= d_in;
      cap_x  <= x_in;
      lat    <= '0;
    end else if (lat != 8'hFF) begin
      lat <= lat + 1'b1;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && int'(lat) == ((cap_op == 2'd0) ? H : W)));

  // R1
  mul_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_op == 2'd0) |->
      (res_d == ({{H{1'b0}}, cap_d[W-1:H]} * {{H{1'b0}}, cap_d[H-1:0]})
       && res_x == cap_x && flag_c == res_d[H-1] && !flag_v));

  // R2
  idiv_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_op == 2'd1 && cap_x != '0) |->
      (res_x == cap_d / cap_x && res_d == cap_d % cap_x && !flag_c && !flag_v));

  // R4
  div0_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_op != 2'd0 && cap_x == '0) |->
      (flag_c && res_x == '1 && res_d == cap_d));

  // R5
  fdiv_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_op == 2'd2 && cap_x != '0 && cap_d >= cap_x) |->
      (flag_v && !flag_c && res_x == '1 && res_d == cap_d));

  // R6
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_op != 2'd0) |-> (flag_z == (res_x == '0)));

  // R9
  idle_op_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'd3) |=> !busy);

  // R10
  reset_chk: assert property (@(posedge clk)
    rst |=> (!done && !busy && res_x == '0 && res_d == '0));
endmodule

bind muldiv_unit muldiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .d_in(d_in), .x_in(x_in),
  .busy(busy), .done(done), .res_x(res_x), .res_d(res_d),
  .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] d_in = '0, x_in = '0;
  logic        busy, done, flag_c, flag_v, flag_z;
  logic [15:0] res_x, res_d;

  typedef struct {
    logic [15:0] x;
    logic [15:0] d;
    logic        c;
    logic        v;
    logic        z;
    int          due;
  } exp_t;

  exp_t  sb[$];
  string tags[$];
  int    total = 0, bad = 0, pcyc = 0, n_done = 0, n_push = 0;
  bit    finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  muldiv_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .d_in(d_in), .x_in(x_in),
    .busy(busy), .done(done), .res_x(res_x), .res_d(res_d),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
  );

  function automatic exp_t model(logic [1:0] o, logic [15:0] d, logic [15:0] x);
    exp_t e;
    logic [31:0] n;
    e.v = 1'b0; e.c = 1'b0;
    if (o == 2'd0) begin
      e.d = 16'(d[15:8]) * 16'(d[7:0]);
      e.x = x; e.c = e.d[7]; e.z = (e.d == 0);
    end else if (x == 0 || (o == 2'd2 && d >= x)) begin
      e.x = 16'hFFFF; e.d = d; e.c = (x == 0); e.v = (o == 2'd2); e.z = 1'b0;
    end else begin
      n = (o == 2'd2) ? {d, 16'h0} : {16'h0, d};
      e.x = 16'(n / 32'(x)); e.d = 16'(n % 32'(x)); e.z = (e.x == 0);
    end
    e.due = 0;
    return e;
  endfunction

  task automatic check(bit ok, string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic issue(logic [1:0] o, logic [15:0] d, logic [15:0] x, string tag);
    exp_t e;
    @(negedge clk);
    start = 1'b1; op = o; d_in = d; x_in = x;
    e = model(o, d, x);
    e.due = pcyc + 1 + ((o == 2'd0) ? 8 : 16);
    sb.push_back(e); tags.push_back(tag); n_push++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(logic [1:0] o, logic [15:0] d, logic [15:0] x, string tag);
    issue(o, d, x, tag);
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (sb.size() == 0) begin
        check(0, $sformatf("R8/R9 unexpected done: actual x=%h d=%h expected none",
                           res_x, res_d));
      end else begin
        exp_t  e;
        string t;
        e = sb.pop_front();
        t = tags.pop_front();
        check(pcyc == e.due, $sformatf("%s R7 latency: actual edge %0d expected %0d",
                                       t, pcyc, e.due));
        check(res_x == e.x && res_d == e.d && flag_c == e.c && flag_v == e.v
              && flag_z == e.z,
              $sformatf("%s: actual x=%h d=%h c=%b v=%b z=%b expected x=%h d=%h c=%b v=%b z=%b",
                        t, res_x, res_d, flag_c, flag_v, flag_z,
                        e.x, e.d, e.c, e.v, e.z));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog: actual hung expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && res_x == 0 && res_d == 0 && !flag_c && !flag_v && !flag_z,
          $sformatf("R10 reset: actual busy=%b done=%b x=%h d=%h expected all zero",
                    busy, done, res_x, res_d));
    rst = 1'b0;
    @(negedge clk);

    run(2'd0, 16'hFFFF, 16'h1234, "R1 mul ff*ff");
    run(2'd0, 16'h1234, 16'h0001, "R1 mul 12*34 carry");
    run(2'd0, 16'h00A5, 16'hBEEF, "R6 mul zero");
    // R10 results hold between operations
    repeat (5) @(negedge clk);
    check(res_d == 16'h0000 && res_x == 16'hBEEF && flag_z,
          $sformatf("R10 hold: actual x=%h d=%h z=%b expected x=beef d=0000 z=1",
                    res_x, res_d, flag_z));
    run(2'd1, 16'd1000, 16'd7, "R2 idiv 1000/7");
    run(2'd1, 16'hFFFF, 16'h0001, "R2 idiv ffff/1");
    run(2'd1, 16'd5, 16'd9, "R6 idiv zero quotient");
    run(2'd1, 16'h4321, 16'h0000, "R4 idiv by zero");
    run(2'd2, 16'd2, 16'd3, "R3 fdiv 2/3");
    e = model(2'd2, 16'd2, 16'd3);
    run(2'd2, e.d, 16'd3, "R3 fdiv chained remainder");
    run(2'd2, 16'h8000, 16'hFFFF, "R3 fdiv 8000/ffff");
    run(2'd2, 16'd5, 16'd5, "R5 fdiv equal operands");
    run(2'd2, 16'h9000, 16'h1000, "R5 fdiv numerator larger");
    run(2'd2, 16'd7, 16'd0, "R4 fdiv by zero");

    // R8 start while busy
    issue(2'd1, 16'd50000, 16'd123, "R8 busy restart ignored");
    repeat (3) @(negedge clk);
    start = 1'b1; op = 2'd0; d_in = 16'h0202; x_in = 16'h5555;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(n_done == n_push, $sformatf("R8 done count: actual %0d expected %0d",
                                      n_done, n_push));

    // R9 op code 3 ignored
    start = 1'b1; op = 2'd3; d_in = 16'h1111; x_in = 16'h2222;
    @(negedge clk);
    start = 1'b0;
    check(!busy, $sformatf("R9 idle op busy: actual %b expected 0", busy));
    repeat (20) @(negedge clk);
    check(n_done == n_push, $sformatf("R9 done count: actual %0d expected %0d",
                                      n_done, n_push));

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule